// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block sits beside a load queue in an out-of-order core. It keeps one entry per load in flight, in program order. An entry records the cache line the load reads, whether that line lies in a coherent region, and whether the load has already obtained its value. Coherence traffic (invalidations and snoops) is presented on the snoop input. The hazard it catches is a load that obtained its value ahead of an older, still unfinished load, followed by a remote store to that line. Without a replay the two loads would appear reordered. When this happens the block raises a flush request and returns the slot tag of the offending load. The pipeline then discards that load and everything younger and restarts execution at that load.

A load stops needing protection as soon as every older load has obtained its value. For that reason the oldest load in the queue is never a flush target. Loads to non-coherent regions are never protected. Slot tags are handed out by the block on the allocation handshake and are used again by the pipeline to report value binding. Retirement always frees the oldest entry.

Allocation is a valid/ready stream. A load is accepted in a cycle where `alloc_valid` and `alloc_ready` are both high, and `alloc_tag` names its slot in that same cycle. `alloc_ready` is low while all slots are occupied and during any cycle in which a flush is requested. The producer must then hold the load and offer it again. Bind, retire and snoop are single-cycle pulses with no back-pressure.

Top module: `lovd_detector`

## Requirements
- R1: After reset the queue is empty: `flush_valid` is 0, `alloc_ready` is 1 and the first accepted load receives tag 0.
- R2: Accepted loads receive consecutive slot tags that wrap from DEPTH-1 to 0. `alloc_ready` is 0 while DEPTH loads are held, and a load offered then is not accepted.
- R3: A retire pulse frees the oldest entry. A retire pulse with an empty queue has no effect.
- R4: A snoop whose line matches a coherent load that has obtained its value and still has an older load without a value raises `flush_valid` in the same cycle, with `flush_tag` equal to that load's tag.
- R5: Lines are compared on address bits [ADDR_W-1:LINE_OFS_W] only. Addresses that differ only in the low LINE_OFS_W bits match, and a difference in any higher bit prevents a match.
- R6: A load that has not yet obtained its value never causes a flush.
- R7: A load stops being watched once every older load in the queue has obtained its value. In particular, the oldest load never causes a flush.
- R8: A load allocated with `alloc_coherent` = 0 never causes a flush.
- R9: When a snoop matches several watched loads, `flush_tag` names the oldest of them.
- R10: In a flush cycle, the flushed load and all younger loads are removed and `alloc_ready` is 0. The next accepted load receives the flushed tag, while older loads stay tracked. A retire pulse in the same cycle still frees the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | A new load is offered |
| alloc_ready | output | 1 | The block can accept the offered load |
| alloc_addr | input | ADDR_W | Address read by the new load |
| alloc_coherent | input | 1 | 1 if the load targets a coherent region |
| alloc_tag | output | TAG_W | Slot tag given to the load accepted this cycle |
| bind_valid | input | 1 | A load has obtained its value |
| bind_tag | input | TAG_W | Slot tag of that load |
| retire_valid | input | 1 | The oldest load retires |
| snoop_valid | input | 1 | An invalidation or snoop is present |
| snoop_addr | input | ADDR_W | Address of the snoop |
| flush_valid | output | 1 | Flush and restart request |
| flush_tag | output | TAG_W | Tag of the load at which execution restarts |

## Verification
The hardest situation to reach is a snoop that lands on a load whose watch status depends on the bind state of every older load, while the queue pointers sit at an arbitrary wrap position. The bench gets there with a sweep over a four-slot queue. It first rotates the head by allocating and retiring zero to three dummy loads. It then fills the queue with lines chosen so that two entries share a line, binds every subset of the entries and marks every subset as coherent. Finally it fires snoops to each stored line and to an absent one. Directed sequences then cover a flush combined with a retire, and reuse of the flushed slot.

// File: rtl/lovd_pkg.sv
`timescale 1ns/1ps
package lovd_pkg;

  // Position reached by stepping ofs places forward from base in a ring of depth slots.
  function automatic int ring_pos(input int base, input int ofs, input int depth);
    return (base + ofs) % depth;
  endfunction

  // Distance from base forward to pos in a ring of depth slots.
  function automatic int ring_dist(input int base, input int pos, input int depth);
    return (pos + depth - base) % depth;
  endfunction

endpackage

// File: rtl/lovd_entry_match.sv
`timescale 1ns/1ps
module lovd_entry_match #(
  parameter int LINE_W = 26
) (
  input  logic              live,
  input  logic              bound,
  input  logic              coherent,
  input  logic [LINE_W-1:0] line,
  input  logic              snoop_valid,
  input  logic [LINE_W-1:0] snoop_line,
  output logic              hit
);
  // Raw hit: occupied, value obtained, coherent region, same cache line.
  assign hit = live && bound && coherent && snoop_valid && (line == snoop_line);
endmodule

// File: rtl/lovd_oldest_pick.sv
`timescale 1ns/1ps
module lovd_oldest_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] head,
  input  logic [DEPTH-1:0] live,
  input  logic [DEPTH-1:0] bound,
  input  logic [DEPTH-1:0] hit,
  output logic             found,
  output logic [IDX_W-1:0] pick_idx,
  output logic [IDX_W-1:0] pick_ofs
);
  // Walk slots oldest first; a hit counts only while some older load is unbound.
  always_comb begin
    logic all_older_bound;
    int   p;
    found           = 1'b0;
    pick_idx        = '0;
    pick_ofs        = '0;
    all_older_bound = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      p = lovd_pkg::ring_pos(int'(head), k, DEPTH);
      if (!found && hit[p] && !all_older_bound) begin
        found    = 1'b1;
        pick_idx = IDX_W'(p);
        pick_ofs = IDX_W'(k);
      end
      if (live[p]) all_older_bound = all_older_bound & bound[p];
    end
  end
endmodule

// File: rtl/lovd_ring_ctrl.sv
`timescale 1ns/1ps
module lovd_ring_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  input  logic [IDX_W-1:0] flush_idx,
  input  logic [IDX_W-1:0] flush_ofs,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  logic [IDX_W-1:0] head_step, tail_step;

  assign head_step = IDX_W'(lovd_pkg::ring_pos(int'(head), 1, DEPTH));
  assign tail_step = IDX_W'(lovd_pkg::ring_pos(int'(tail), 1, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (retire_fire) head <= head_step;
      if (flush) begin
        // Keep only the entries older than the restart slot.
        tail  <= flush_idx;
        count <= CNT_W'(flush_ofs) - CNT_W'(retire_fire);
      end else begin
        if (alloc_fire) tail <= tail_step;
        count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
      end
    end
  end
endmodule

// File: rtl/lovd_detector.sv
`timescale 1ns/1ps
module lovd_detector #(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_OFS_W = 6,
  localparam int TAG_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              alloc_coherent,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              bind_valid,
  input  logic [TAG_W-1:0]  bind_tag,
  input  logic              retire_valid,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              flush_valid,
  output logic [TAG_W-1:0]  flush_tag
);
  localparam int LINE_W = ADDR_W - LINE_OFS_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [TAG_W-1:0]  head, tail, pick_idx, pick_ofs;
  logic [CNT_W-1:0]  count;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [DEPTH-1:0]  bound_q, coh_q, live, hit;
  logic [LINE_W-1:0] alloc_line, snoop_line;
  logic              alloc_fire, retire_fire, pick_found;

  assign alloc_line  = LINE_W'(alloc_addr >> LINE_OFS_W);
  assign snoop_line  = LINE_W'(snoop_addr >> LINE_OFS_W);
  assign alloc_ready = (count < CNT_W'(DEPTH)) && !pick_found;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire_fire = retire_valid && (count != '0);
  assign alloc_tag   = tail;
  assign flush_valid = pick_found;
  assign flush_tag   = pick_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [TAG_W-1:0] age;
    assign age     = TAG_W'(lovd_pkg::ring_dist(int'(head), i, DEPTH));
    assign live[i] = CNT_W'(age) < count;

    lovd_entry_match #(.LINE_W(LINE_W)) i_match (
      .live        (live[i]),
      .bound       (bound_q[i]),
      .coherent    (coh_q[i]),
      .line        (line_q[i]),
      .snoop_valid (snoop_valid),
      .snoop_line  (snoop_line),
      .hit         (hit[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bound_q[i] <= 1'b0;
        coh_q[i]   <= 1'b0;
        line_q[i]  <= '0;
      end else if (alloc_fire && (tail == TAG_W'(i))) begin
        bound_q[i] <= 1'b0;
        coh_q[i]   <= alloc_coherent;
        line_q[i]  <= alloc_line;
      end else if (bind_valid && (bind_tag == TAG_W'(i))) begin
        bound_q[i] <= 1'b1;
      end
    end
  end

  lovd_oldest_pick #(.DEPTH(DEPTH)) i_pick (
    .head     (head),
    .live     (live),
    .bound    (bound_q),
    .hit      (hit),
    .found    (pick_found),
    .pick_idx (pick_idx),
    .pick_ofs (pick_ofs)
  );

  lovd_ring_ctrl #(.DEPTH(DEPTH)) i_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .retire_fire (retire_fire),
    .flush       (pick_found),
    .flush_idx   (pick_idx),
    .flush_ofs   (pick_ofs),
    .head        (head),
    .tail        (tail),
    .count       (count)
  );

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_oldest_never_flushed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (flush_tag != head));

  assert_target_bound_coherent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (coh_q[flush_tag] && bound_q[flush_tag] && live[flush_tag]));

  assert_flush_truncates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (alloc_tag == $past(flush_tag)));

  assert_flush_needs_snoop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> snoop_valid);
endmodule

// File: tb/test_lovd_detector.sv
`timescale 1ns/1ps
module test_lovd_detector;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int OFSW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0, alloc_coherent = 1'b0;
  logic [AW-1:0] alloc_addr = '0, snoop_addr = '0;
  logic          alloc_ready, flush_valid;
  logic [1:0]    alloc_tag, flush_tag, bind_tag = '0;
  logic          bind_valid = 1'b0, retire_valid = 1'b0, snoop_valid = 1'b0;

  int n_checks = 0;
  int n_err    = 0;

  always #5 clk = ~clk;

  lovd_detector #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_OFS_W(OFSW)) i_lovd_detector (
    .clk, .rst_n, .alloc_valid, .alloc_ready, .alloc_addr, .alloc_coherent, .alloc_tag,
    .bind_valid, .bind_tag, .retire_valid, .snoop_valid, .snoop_addr, .flush_valid, .flush_tag
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_alloc(input int addr, input bit coh);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_addr = AW'(addr); alloc_coherent = coh;
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic do_bind(input int tag);
    @(negedge clk);
    bind_valid = 1'b1; bind_tag = 2'(tag);
    @(posedge clk); #1;
    bind_valid = 1'b0;
  endtask

  task automatic do_retire();
    @(negedge clk);
    retire_valid = 1'b1;
    @(posedge clk); #1;
    retire_valid = 1'b0;
  endtask

  // Snoop with optional retire; checks flush output in the same cycle (code 0 = none, 10+tag = flush).
  task automatic do_snoop(input int addr, input bit ret, input bit exp_v, input int exp_tag, input string req);
    int act, exp;
    @(negedge clk);
    snoop_valid = 1'b1; snoop_addr = AW'(addr); retire_valid = ret;
    #1;
    act = flush_valid ? 10 + int'(flush_tag) : 0;
    exp = exp_v ? 10 + exp_tag : 0;
    chk(act == exp, req, act, exp);
    if (exp_v) chk(alloc_ready == 1'b0, "R10 ready low in flush cycle", int'(alloc_ready), 0);
    @(posedge clk); #1;
    snoop_valid = 1'b0; retire_valid = 1'b0;
  endtask

  task automatic sample(output logic rdy, output int tag);
    @(negedge clk); #1;
    rdy = alloc_ready; tag = int'(alloc_tag);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    int   lines [4];
    int   snoops [4];
    logic rdy;
    int   tg;
    lines  = '{5, 9, 12, 9};
    snoops = '{(9 << 2) | 3, (5 << 2) | 2, (12 << 2) | 1, (7 << 2) | 0};

    // R1: reset state
    do_reset();
    sample(rdy, tg);
    chk(rdy == 1'b1, "R1 ready after reset", int'(rdy), 1);
    chk(flush_valid == 1'b0, "R1 no flush after reset", int'(flush_valid), 0);
    chk(tg == 0, "R1 first tag", tg, 0);

    // R2 R3: fill, backpressure, retire on empty
    do_retire();
    sample(rdy, tg);
    chk(tg == 0, "R3 retire on empty ignored", tg, 0);
    for (int i = 0; i < 4; i++) begin
      sample(rdy, tg);
      chk(tg == i, "R2 consecutive tags", tg, i);
      do_alloc(i << 2, 1'b1);
    end
    sample(rdy, tg);
    chk(rdy == 1'b0, "R2 ready low when full", int'(rdy), 0);
    do_alloc(8'h40, 1'b1);
    sample(rdy, tg);
    chk(tg == 0, "R2 offered load not taken when full", tg, 0);
    do_retire();
    sample(rdy, tg);
    chk(rdy == 1'b1, "R3 retire frees a slot", int'(rdy), 1);
    do_alloc(8'h50, 1'b1);
    sample(rdy, tg);
    chk(tg == 1, "R2 tag wraps", tg, 1);

    // R5: line granularity, high bit differs
    do_reset();
    do_alloc(8'h11, 1'b1); do_alloc(8'h25, 1'b1);
    do_bind(1);
    do_snoop(8'hA5, 1'b0, 1'b0, 0, "R5 high line bit differs");
    do_snoop(8'h21, 1'b0, 1'b0, 0, "R5 low line bit differs");
    do_snoop(8'h26, 1'b0, 1'b1, 1, "R5 offset bits ignored");

    // R10: truncation, reuse, older kept
    do_reset();
    for (int i = 0; i < 4; i++) do_alloc((i + 1) << 2, 1'b1);
    do_bind(1); do_bind(2); do_bind(3);
    do_snoop(3 << 2, 1'b0, 1'b1, 2, "R10 flush on entry 2");
    sample(rdy, tg);
    chk(tg == 2, "R10 next tag is flushed tag", tg, 2);
    do_snoop(4 << 2, 1'b0, 1'b0, 0, "R10 younger entry removed");
    do_snoop(2 << 2, 1'b0, 1'b1, 1, "R10 older entry kept");

    // R10: retire in the flush cycle
    do_reset();
    for (int i = 0; i < 3; i++) do_alloc((i + 1) << 2, 1'b1);
    do_bind(2);
    do_snoop(3 << 2, 1'b1, 1'b1, 2, "R10 flush with retire");
    for (int i = 0; i < 3; i++) do_alloc(8'h80, 1'b0);
    sample(rdy, tg);
    chk(rdy == 1'b0, "R10 count after flush with retire", int'(rdy), 0);

    // Sweep: R4 R6 R7 R8 R9 over head rotation, bind mask, coherent mask, snoop line
    for (int r = 0; r < 4; r++) begin
      for (int bm = 0; bm < 16; bm++) begin
        for (int cm = 0; cm < 16; cm++) begin
          for (int s = 0; s < 4; s++) begin
            bit found, older_all;
            int etag;
            do_reset();
            for (int k = 0; k < r; k++) begin
              do_alloc(0, 1'b1);
              do_retire();
            end
            for (int i = 0; i < 4; i++) do_alloc((lines[i] << 2) | i, cm[i]);
            for (int i = 3; i >= 0; i--) if (bm[i]) do_bind((r + i) % 4);
            found = 1'b0; older_all = 1'b1; etag = 0;
            for (int i = 0; i < 4; i++) begin
              if (!found && bm[i] && cm[i] && !older_all && (lines[i] == (snoops[s] >> 2))) begin
                found = 1'b1;
                etag  = (r + i) % 4;
              end
              older_all = older_all & bm[i];
            end
            do_snoop(snoops[s], 1'b0, found, etag, "R4 R6 R7 R8 R9 sweep");
          end
        end
      end
    end

    report();
  end
endmodule